// File: doc/BRIEF.md
# Status-Mapped Data Memory

This block is the data memory of a small CPU. It holds eight 32-bit words. The three lowest words are kept up to date by hardware. The other five are plain read/write storage. The CPU reaches every word through one port that is addressed by word.

The hardware words have these jobs:

- Word 0 is a free-running cycle counter.
- Word 1 holds the most recent byte from the serial loader, together with a flag that shows whether that byte is new.
- Word 2 holds the last instruction word that the loader committed to instruction memory.

Firmware finds out how long it has been running by reading word 0. It polls word 1 for incoming bytes. It reads word 2 to confirm what was programmed. Reads are combinational, so a load sees data in the same cycle it presents the address. Stores to the general words take effect at the next clock edge. Stores to the hardware words are dropped.

Top module: `sysstat_dmem`

## Requirements
- R1: While `rst_n` is low, every word reads zero: the counter, the receive status, the instruction copy and all five general words.
- R2: Word 0 returns a `CNT_W`-bit counter, zero-extended to 32 bits. It advances by one on every clock edge out of reset and wraps to zero after reaching all ones. A 32-bit counter wraps after 0xFFFFFFFF.
- R3: Word 1 has this layout: bits 7:0 hold the last byte presented with `rx_stb`, bit 8 is the new-byte flag, and bits 31:9 always read zero.
- R4: The new-byte flag works as follows:
  - It sets on the edge where `rx_stb` is high.
  - It clears on the edge where `cpu_rd_en` is high with address 1 and `rx_stb` is low.
  - If a strobe and such a read happen in the same cycle, the flag stays set and the read returns the value from before the edge.
  - Clearing the flag keeps the byte.
- R5: Word 2 loads `instr_word` only on an edge where `instr_wr_stb` is high. At any other time it holds its value.
- R6: Stores to words 0, 1 and 2 change nothing that a read can see. The counter keeps its normal count.
- R7: A store to word 3 to 7 is visible from the next clock edge on. A later store to the same word replaces it.
- R8: An address of 8 or more reads zero. A store to such an address does not alter any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| cpu_addr | input | AW (8) | Word address from the CPU |
| cpu_rd_en | input | 1 | Load in progress; used only to clear the word 1 flag |
| cpu_wr_en | input | 1 | Store strobe |
| cpu_wdata | input | DW (32) | Store data |
| cpu_rdata | output | DW (32) | Combinational read data |
| rx_stb | input | 1 | A new serial byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| instr_wr_stb | input | 1 | The loader commits an instruction word |
| instr_word | input | DW (32) | Instruction word being committed |

## Verification
The assertions assume the following about the inputs:

- `rx_byte` and `instr_word` are meaningful only in cycles where their strobes are high.
- A load that clears the receive flag is marked by `cpu_rd_en` together with address 1.
- `CNT_W` is no wider than the data word.

The stimulus drives every input half a cycle away from the sampling edge, so each strobe covers exactly one edge. It holds `cpu_rd_en` low during the address sweeps, so those sweeps cannot clear the flag by accident. A second instance with an 8-bit counter checks the wrap in a few hundred cycles instead of four billion.

// File: rtl/sysstat_dmem.sv
module sysstat_dmem #(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int WORDS = 8,
  parameter int CNT_W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rd_en,
  input  logic          cpu_wr_en,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          rx_stb,
  input  logic [7:0]    rx_byte,
  input  logic          instr_wr_stb,
  input  logic [DW-1:0] instr_word
);
  localparam int SYS = 3;
  localparam int GP  = WORDS - SYS;
  localparam int IW  = (GP > 1) ? $clog2(GP) : 1;

  logic [CNT_W-1:0]       cnt_q;
  logic                   rx_valid_q;
  logic [7:0]             rx_byte_q;
  logic [DW-1:0]          instr_q;
  logic [GP-1:0][DW-1:0]  mem_q;

  wire          in_range = 32'(cpu_addr) < WORDS;
  wire          is_rx    = cpu_addr == AW'(1);
  wire          gp_hit   = in_range && (32'(cpu_addr) >= SYS);
  wire [AW-1:0] gp_off   = cpu_addr - AW'(SYS);
  wire [IW-1:0] gp_idx   = gp_off[IW-1:0];

  always_ff @(posedge clk)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n) begin
      rx_valid_q <= 1'b0;
      rx_byte_q  <= '0;
    end else if (rx_stb) begin
      rx_valid_q <= 1'b1;
      rx_byte_q  <= rx_byte;
    end else if (cpu_rd_en && is_rx) begin
      rx_valid_q <= 1'b0;
    end

  always_ff @(posedge clk)
    if (!rst_n)            instr_q <= '0;
    else if (instr_wr_stb) instr_q <= instr_word;

  for (genvar g = 0; g < GP; g++) begin : g_slot
    always_ff @(posedge clk)
      if (!rst_n)                                          mem_q[g] <= '0;
      else if (cpu_wr_en && gp_hit && gp_idx == IW'(g))    mem_q[g] <= cpu_wdata;
  end

  always_comb begin
    cpu_rdata = '0;
    if (in_range) begin
      if (cpu_addr == AW'(0))      cpu_rdata = DW'(cnt_q);
      else if (is_rx)              cpu_rdata = DW'({rx_valid_q, rx_byte_q});
      else if (cpu_addr == AW'(2)) cpu_rdata = instr_q;
      else                         cpu_rdata = mem_q[gp_idx];
    end
  end
endmodule

// File: rtl/sysstat_dmem_chk.sv
module sysstat_dmem_chk #(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int WORDS = 8,
  parameter int CNT_W = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [AW-1:0]                cpu_addr,
  input logic                         cpu_rd_en,
  input logic                         cpu_wr_en,
  input logic [DW-1:0]                cpu_rdata,
  input logic                         rx_stb,
  input logic [7:0]                   rx_byte,
  input logic                         instr_wr_stb,
  input logic [DW-1:0]                instr_word,
  input logic [CNT_W-1:0]             cnt_q,
  input logic                         rx_valid_q,
  input logic [7:0]                   rx_byte_q,
  input logic [DW-1:0]                instr_q,
  input logic [WORDS-4:0][DW-1:0]     mem_q
);
  wire gp_store = cpu_wr_en && (32'(cpu_addr) >= 3) && (32'(cpu_addr) < WORDS);

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_rx_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr == AW'(1) |-> cpu_rdata[DW-1:9] == '0);

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |=> rx_valid_q && rx_byte_q == $past(rx_byte));

  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_en && cpu_addr == AW'(1) && !rx_stb |=> !rx_valid_q && $stable(rx_byte_q));

  assert_instr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_wr_stb |=> $stable(instr_q));

  assert_instr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    instr_wr_stb |=> instr_q == $past(instr_word));

  assert_ram_untouched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gp_store |=> $stable(mem_q));

  assert_oob_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cpu_addr) >= WORDS |-> cpu_rdata == '0);
endmodule

bind sysstat_dmem sysstat_dmem_chk #(.DW(DW), .AW(AW), .WORDS(WORDS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd_en(cpu_rd_en),
  .cpu_wr_en(cpu_wr_en), .cpu_rdata(cpu_rdata), .rx_stb(rx_stb), .rx_byte(rx_byte),
  .instr_wr_stb(instr_wr_stb), .instr_word(instr_word), .cnt_q(cnt_q),
  .rx_valid_q(rx_valid_q), .rx_byte_q(rx_byte_q), .instr_q(instr_q), .mem_q(mem_q)
);

// File: tb/sysstat_dmem_tb.sv
`timescale 1ns/1ps
module sysstat_dmem_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic        cpu_rd_en = 1'b0;
  logic        cpu_wr_en = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] rdata, rdata_w;
  logic        rx_stb = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        instr_wr_stb = 1'b0;
  logic [31:0] instr_word = '0;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sysstat_dmem u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd_en(cpu_rd_en),
    .cpu_wr_en(cpu_wr_en), .cpu_wdata(cpu_wdata), .cpu_rdata(rdata),
    .rx_stb(rx_stb), .rx_byte(rx_byte), .instr_wr_stb(instr_wr_stb), .instr_word(instr_word));

  sysstat_dmem #(.CNT_W(8)) u_wrap (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd_en(cpu_rd_en),
    .cpu_wr_en(cpu_wr_en), .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_w),
    .rx_stb(rx_stb), .rx_byte(rx_byte), .instr_wr_stb(instr_wr_stb), .instr_word(instr_word));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic clr, output logic [31:0] v);
    cpu_addr = a; cpu_rd_en = clr;
    #1 v = rdata;
    @(negedge clk);
    cpu_rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr_en = 1'b1;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int a, input int k);
    return 32'hA5C3_0F96 ^ (32'(a) * 32'h0101_0101) ^ (32'(k) * 32'h1357_9BDF);
  endfunction

  function automatic logic [31:0] ins(input int i);
    return 32'(i) * 32'h9E37_79B9 + 32'h13;
  endfunction

  initial begin
    #(150000 * 5);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v0, v1, w;
    logic [31:0] last_ins;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 12; a++) begin
      cpu_addr = 8'(a); #0.1;
      chk("R1 reset read zero", rdata, 32'h0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    rd(0, 0, v0);
    repeat (36) @(negedge clk);
    rd(0, 0, v1);
    chk("R2 counter delta", v1 - v0, 32'd37);

    cpu_addr = 0; #1;
    for (int n = 0; n < 300 && rdata_w !== 32'd255; n++) begin
      @(negedge clk); #1;
    end
    chk("R2 narrow counter reaches max", rdata_w, 32'd255);
    @(negedge clk); #1;
    chk("R2 narrow counter wraps", rdata_w, 32'd0);
    @(negedge clk);

    for (int b = 0; b < 256; b++) begin
      rx_byte = 8'(b); rx_stb = 1'b1;
      @(negedge clk);
      rx_stb = 1'b0;
      rd(1, 1, v);
      chk("R3 R4 byte and flag after strobe", v, 32'h100 | 32'(b));
      rd(1, 1, v);
      chk("R4 flag cleared, byte kept", v, 32'(b));
    end

    rx_byte = 8'h3C; rx_stb = 1'b1; @(negedge clk); rx_stb = 1'b0;
    rx_byte = 8'hE1; rx_stb = 1'b1;
    rd(1, 1, v);
    rx_stb = 1'b0;
    chk("R4 simultaneous read sees old value", v, 32'h13C);
    rd(1, 1, v);
    chk("R4 strobe wins over clear", v, 32'h1E1);
    rd(1, 0, v);
    chk("R4 flag cleared by prior read", v, 32'h0E1);
    rd(1, 0, v);
    chk("R4 read without rd_en keeps flag", v, 32'h0E1);

    last_ins = 32'h0;
    for (int i = 1; i <= 16; i++) begin
      instr_word = ins(i); instr_wr_stb = 1'b0;
      @(negedge clk);
      rd(2, 1, v);
      chk("R5 no strobe holds word 2", v, last_ins);
      instr_wr_stb = 1'b1;
      @(negedge clk);
      instr_wr_stb = 1'b0;
      instr_word = ~ins(i);
      last_ins = ins(i);
      rd(2, 1, v);
      chk("R5 strobe loads word 2", v, last_ins);
    end

    for (int k = 0; k < 2; k++) begin
      for (int a = 3; a < 8; a++) wr(8'(a), pat(a, k));
      for (int a = 0; a < 256; a++) begin
        if (a >= 3) begin
          rd(8'(a), 0, v);
          if (a < 8) chk("R7 general word readback", v, pat(a, k));
          else       chk("R8 out-of-range read zero", v, 32'h0);
        end
      end
    end

    wr(8'd5, 32'hDEAD_BEEF);
    rd(8'd5, 0, v);
    chk("R7 store visible next cycle", v, 32'hDEAD_BEEF);
    wr(8'd5, pat(5, 1));

    for (int a = 8; a < 256; a += 7) wr(8'(a), 32'hFFFF_FFFF);
    for (int a = 3; a < 8; a++) begin
      rd(8'(a), 0, v);
      chk("R8 out-of-range store no alias", v, pat(a, 1));
    end

    rd(0, 0, v0);
    wr(0, 32'h1234_5678);
    rd(0, 0, v1);
    chk("R6 store to word 0 ignored", v1 - v0, 32'd2);
    wr(1, 32'hFFFF_FFFF);
    rd(1, 0, v);
    chk("R6 store to word 1 ignored", v, 32'h0E1);
    wr(2, 32'h0BAD_F00D);
    rd(2, 0, v);
    chk("R6 store to word 2 ignored", v, last_ins);
    for (int a = 3; a < 8; a++) begin
      rd(8'(a), 0, w);
      chk("R6 general words untouched", w, pat(a, 1));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule